// File: doc/BRIEF.md
# Tick-Prescaled Watchdog Countdown Timer

This block is a system watchdog behind a 32-byte register window. A prescaler divides the core clock into slow countdown ticks, nominally 0.6 s each. A 10-bit down-counter counts those ticks. Software must refresh the counter by writing to a reload register before the count runs out. Software can also freeze the timer, read the remaining count, change the initial value and clear the sticky status flags.

Running out of count once only raises a sticky timeout flag, and the counter starts again from the initial value. If the count runs out a second time while that flag is still set, the block issues a one-cycle reset request. A reboot-block control can suppress that request. The control is the OR of a software bit and a hardware strap input, and it reads back as that OR, so software can tell when hardware is forcing it. Register accesses are single-cycle read and write strobes with 16-bit data. Offsets are byte addresses and registers sit at even offsets.

Top module: `tick_watchdog`

## Requirements
- R1: After a synchronous reset the block is in its default state. Halt (control offset 0x08, bit 11) reads 1 and the software reboot-block bit (offset 0x08, bit 0) reads 1. The initial value and the live count are both 50. Both status registers read 0, `wdt_reset_o` is 0 and `bus_rdata` is 0.
- R2: While halt is 0, one tick arrives every TICK_DIV clock cycles and the live count decreases by one per tick. While halt is 1 the count holds and the prescaler is held cleared.
- R3: A write to offset 0x08 sets halt from data bit 11 and the software reboot-block bit from data bit 0. The new halt value governs counting from the following cycle on.
- R4: A write of any data to offset 0x00 reloads the live count from the initial value on the next edge. A read of offset 0x00 returns the live count in bits 9:0, with bits 15:10 at zero.
- R5: Offset 0x12 holds the initial value in bits 9:0. A write whose bits 9:0 are below 4 leaves the previous initial value in place. Bits 15:10 always store the written data and read back unchanged. A new initial value is used only at the next reload.
- R6: An expiry is a tick that arrives while the count is 0. It reloads the count from the initial value and sets the timeout flag, bit 3 of offset 0x04.
- R7: An expiry while the timeout flag is already set also sets bit 1 of offset 0x06. In the next cycle it drives `wdt_reset_o` high for exactly one cycle, unless reboot-block is active.
- R8: Reboot-block is active when the software bit or `hw_no_reset` is 1. While it is active, no reset request is issued. Bit 0 of offset 0x08 reads back the OR of the two.
- R9: Writing 1 to bit 3 of 0x04 clears the timeout flag, and writing 1 to bit 1 of 0x06 clears the second-expiry flag. Writing 0 to those bits has no effect. If an expiry sets a flag in the same cycle that a write clears it, the flag ends up set.
- R10: If a reload write and an expiry fall in the same cycle, the reload wins. The count takes the initial value and no status flag changes.
- R11: Reads of unmapped offsets in the window, odd offsets included, return 0. Writes to unmapped offsets change nothing.
- R12: Read data is registered. It appears on `bus_rdata` the cycle after the read strobe, and `bus_rdata` is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset inside the 32-byte window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| hw_no_reset | input | 1 | Hardware strap that forces reboot-block on |
| wdt_reset_o | output | 1 | One-cycle reset request |

## Verification
On every cycle, assertions check the following:
- The count steps down by exactly one on a tick, holds when there is neither a tick nor a reload, and reloads after a reload write or an expiry.
- An expiry always leaves the timeout flag set.
- The stored initial value never drops below 4.
- The reset request never lasts longer than one cycle and never follows a cycle in which reboot-block was active.
- A halted prescaler produces no tick.

Some behaviours depend on cycle alignment and can only be shown by bench scenarios timed to the exact edge. These are a reload colliding with an expiry, a clear colliding with a set, the rejection of small initial values, and the readback of the strap through the control register.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT_A = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT_B = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT   = 5'h12;

  localparam int HALT_BIT    = 11;
  localparam int BLOCK_BIT   = 0;
  localparam int TIMEOUT_BIT = 3;
  localparam int SECOND_BIT  = 1;
  localparam int MIN_INIT    = 4;

  typedef struct packed {
    logic halt;
    logic block;
  } ctrl_t;
endpackage

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int DIV = 60_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] cnt;
      logic          at_end;
      assign at_end = (cnt == PW'(DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (at_end)  cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
      assign tick = run && at_end;

      // R2/R3: a halted prescaler restarts from zero, so no tick follows
      a_r3_halt_no_tick: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tw_countdown.sv
module tw_countdown #(
  parameter int CW        = 10,
  parameter int RESET_VAL = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          kick,
  input  logic [CW-1:0] init_val,
  output logic [CW-1:0] count,
  output logic          expire
);
  logic at_zero;
  assign at_zero = (count == '0);
  // reload write has priority over an expiry in the same cycle (R10)
  assign expire  = tick && !kick && at_zero;

  always_ff @(posedge clk) begin
    if (rst)                  count <= CW'(RESET_VAL);
    else if (kick || expire)  count <= init_val;
    else if (tick)            count <= count - 1'b1;
  end

  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    (tick && !kick && !at_zero) |=> (count == $past(count) - 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !kick) |=> $stable(count));
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count == $past(init_val)));
  a_r6_expiry_reload: assert property (@(posedge clk) disable iff (rst)
    expire |=> (count == $past(init_val)));
endmodule

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
#(
  parameter int CW         = 10,
  parameter int RESET_INIT = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CW-1:0]     count,
  input  logic              expire,
  input  logic              strap,
  output logic              halt,
  output logic              kick,
  output logic [CW-1:0]     init_val,
  output logic [DATA_W-1:0] rdata,
  output logic              reset_req
);
  localparam int HW = DATA_W - CW;

  ctrl_t             ctrl_q;
  logic [CW-1:0]     init_q;
  logic [HW-1:0]     init_hi_q;
  logic              to_q, sec_q, req_q;
  logic [DATA_W-1:0] rdata_q, rd_val;
  logic              wr_ctrl, wr_init, clr_to, clr_sec, second, block_eff;

  assign kick      = wr && (addr == OFS_RELOAD);
  assign wr_ctrl   = wr && (addr == OFS_CTRL);
  assign wr_init   = wr && (addr == OFS_INIT);
  assign clr_to    = wr && (addr == OFS_STAT_A) && wdata[TIMEOUT_BIT];
  assign clr_sec   = wr && (addr == OFS_STAT_B) && wdata[SECOND_BIT];
  assign second    = expire && to_q;
  assign block_eff = ctrl_q.block || strap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '{halt: 1'b1, block: 1'b1};
      init_q    <= CW'(RESET_INIT);
      init_hi_q <= '0;
      to_q      <= 1'b0;
      sec_q     <= 1'b0;
      req_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.halt  <= wdata[HALT_BIT];
        ctrl_q.block <= wdata[BLOCK_BIT];
      end
      if (wr_init) begin
        init_hi_q <= wdata[DATA_W-1:CW];
        if (wdata[CW-1:0] >= CW'(MIN_INIT)) init_q <= wdata[CW-1:0];
      end
      to_q    <= (to_q && !clr_to) || expire;
      sec_q   <= (sec_q && !clr_sec) || second;
      req_q   <= second && !block_eff;
      rdata_q <= rd ? rd_val : '0;
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      OFS_RELOAD: rd_val[CW-1:0]    = count;
      OFS_STAT_A: rd_val[TIMEOUT_BIT] = to_q;
      OFS_STAT_B: rd_val[SECOND_BIT]  = sec_q;
      OFS_CTRL: begin
        rd_val[HALT_BIT]  = ctrl_q.halt;
        rd_val[BLOCK_BIT] = block_eff;
      end
      OFS_INIT:   rd_val = {init_hi_q, init_q};
      default:    rd_val = '0;
    endcase
  end

  assign halt      = ctrl_q.halt;
  assign init_val  = init_q;
  assign rdata     = rdata_q;
  assign reset_req = req_q;

  a_r5_init_floor: assert property (@(posedge clk) disable iff (rst)
    init_q >= CW'(MIN_INIT));
  a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
    expire |=> to_q);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);
  a_r8_blocked: assert property (@(posedge clk) disable iff (rst)
    block_eff |=> !req_q);
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata_q == '0));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tw_pkg::*;
#(
  parameter int TICK_DIV   = 60_000_000,
  parameter int CNT_W      = 10,
  parameter int RESET_INIT = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hw_no_reset,
  output logic              wdt_reset_o
);
  logic             halt, kick, tick, expire;
  logic [CNT_W-1:0] init_val, count;

  tw_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(!halt), .tick(tick)
  );

  tw_countdown #(.CW(CNT_W), .RESET_VAL(RESET_INIT)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick),
    .init_val(init_val), .count(count), .expire(expire)
  );

  tw_regs #(.CW(CNT_W), .RESET_INIT(RESET_INIT)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .count(count), .expire(expire), .strap(hw_no_reset),
    .halt(halt), .kick(kick), .init_val(init_val), .rdata(bus_rdata),
    .reset_req(wdt_reset_o)
  );
endmodule

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, hw_no_reset = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        wdt_reset_o;

  int compared = 0, mismatched = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  tick_watchdog #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_no_reset(hw_no_reset),
    .wdt_reset_o(wdt_reset_o)
  );

  // behavioural reference, advanced once per rising edge
  int m_pre, m_cnt, m_init, m_hi, m_halt, m_blk, m_to, m_sec, m_req, m_rd;
  int n_pre, n_cnt, n_init, n_hi, n_halt, n_blk, n_to, n_sec, n_req, n_rd;
  bit tk, kk, ex, sc;
  int rv;

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_cnt = 50; m_init = 50; m_hi = 0; m_halt = 1; m_blk = 1;
      m_to = 0; m_sec = 0; m_req = 0; m_rd = 0;
    end else begin
      tk = (m_halt == 0) && (m_pre == DIV - 1);
      n_pre = (m_halt != 0 || m_pre == DIV - 1) ? 0 : m_pre + 1;
      kk = bus_wr && bus_addr == 5'h00;
      ex = tk && !kk && m_cnt == 0;
      sc = ex && m_to != 0;
      rv = 0;
      if (bus_addr == 5'h00) rv = m_cnt;
      else if (bus_addr == 5'h04) rv = m_to * 8;
      else if (bus_addr == 5'h06) rv = m_sec * 2;
      else if (bus_addr == 5'h08) rv = m_halt * 2048 + ((m_blk != 0 || hw_no_reset) ? 1 : 0);
      else if (bus_addr == 5'h12) rv = m_hi * 1024 + m_init;
      n_rd = bus_rd ? rv : 0;
      n_cnt = (kk || ex) ? m_init : (tk ? m_cnt - 1 : m_cnt);
      n_to = ((m_to != 0 && !(bus_wr && bus_addr == 5'h04 && bus_wdata[3])) || ex) ? 1 : 0;
      n_sec = ((m_sec != 0 && !(bus_wr && bus_addr == 5'h06 && bus_wdata[1])) || sc) ? 1 : 0;
      n_req = (sc && m_blk == 0 && !hw_no_reset) ? 1 : 0;
      n_halt = m_halt; n_blk = m_blk; n_init = m_init; n_hi = m_hi;
      if (bus_wr && bus_addr == 5'h08) begin n_halt = bus_wdata[11]; n_blk = bus_wdata[0]; end
      if (bus_wr && bus_addr == 5'h12) begin
        n_hi = bus_wdata[15:10];
        if (bus_wdata[9:0] >= 4) n_init = bus_wdata[9:0];
      end
      m_pre = n_pre; m_cnt = n_cnt; m_init = n_init; m_hi = n_hi; m_halt = n_halt;
      m_blk = n_blk; m_to = n_to; m_sec = n_sec; m_req = n_req; m_rd = n_rd;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if (bus_rdata !== 16'(m_rd) || wdt_reset_o !== m_req[0]) begin
        mismatched++;
        $display("FAIL %s cycle compare: rdata=%h rst_o=%b expected rdata=%h rst_o=%b",
                 cur, bus_rdata, wdt_reset_o, 16'(m_rd), m_req[0]);
      end
    end
  end

  int pulses = 0;
  always @(negedge clk) if (wdt_reset_o === 1'b1) pulses++;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input int exp);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    cur = "R1";
    chk("R1 reset no request", wdt_reset_o, 0);
    chk("R12 rdata idle", bus_rdata, 0);
    rd_chk("R1 ctrl default", 5'h08, 16'h0801);
    rd_chk("R1 init default", 5'h12, 50);
    rd_chk("R1 count default", 5'h00, 50);
    rd_chk("R1 status A clear", 5'h04, 0);
    idle(1);
    chk("R12 rdata zero after read", bus_rdata, 0);

    cur = "R11";
    wr(5'h0A, 16'hFFFF);
    rd_chk("R11 unmapped read", 5'h0A, 0);
    rd_chk("R11 odd offset read", 5'h01, 0);
    rd_chk("R11 write ignored", 5'h12, 50);

    cur = "R5";
    wr(5'h12, 16'hFC03);
    rd_chk("R5 small value rejected, upper stored", 5'h12, 16'hFC32);
    wr(5'h12, 16'h0010);
    rd_chk("R5 new init", 5'h12, 16'h0010);
    rd_chk("R5 count untouched by init write", 5'h00, 50);
    cur = "R4";
    wr(5'h00, 16'h0001);
    rd_chk("R4 reload", 5'h00, 16);

    cur = "R3";
    idle(20);
    rd_chk("R3 halted count frozen", 5'h00, 16);
    wr(5'h08, 16'h0001);
    idle(8);
    cur = "R2";
    rd_chk("R2 two ticks in eight cycles", 5'h00, 14);

    cur = "R6";
    wr(5'h12, 16'h0004);
    wr(5'h00, 16'h0001);
    idle(50);
    rd_chk("R6 timeout flag", 5'h04, 8);
    rd_chk("R7 second expiry flag", 5'h06, 2);
    cur = "R8";
    chk("R8 no request while blocked", pulses, 0);
    wr(5'h08, 16'h0000);
    rd_chk("R8 block cleared reads 0", 5'h08, 0);
    hw_no_reset = 1'b1;
    rd_chk("R8 strap reads back", 5'h08, 1);
    idle(40);
    chk("R8 strap blocks request", pulses, 0);
    hw_no_reset = 1'b0;
    cur = "R7";
    idle(20);
    chk("R7 exactly one pulse per expiry period", pulses, 1);

    cur = "R9";
    wr(5'h08, 16'h0801);
    wr(5'h00, 16'h0001);
    wr(5'h04, 16'h0000);
    rd_chk("R9 zero write keeps flag", 5'h04, 8);
    wr(5'h06, 16'h0001);
    rd_chk("R9 wrong bit keeps flag", 5'h06, 2);
    wr(5'h06, 16'h0002);
    rd_chk("R9 second flag cleared", 5'h06, 0);
    wr(5'h04, 16'h0008);
    rd_chk("R9 timeout flag cleared", 5'h04, 0);

    cur = "R10";
    wr(5'h08, 16'h0001);
    idle(19);
    wr(5'h00, 16'h0001);
    rd_chk("R10 kick beats expiry, no flag", 5'h04, 0);
    rd_chk("R10 count reloaded", 5'h00, 4);

    cur = "R9";
    wr(5'h08, 16'h0801);
    wr(5'h00, 16'h0001);
    wr(5'h08, 16'h0001);
    idle(19);
    wr(5'h04, 16'h0008);
    rd_chk("R9 set wins over clear", 5'h04, 8);
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired in %s actual=hung expected=done", cur);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule